// File: doc/BRIEF.md
# Breakpoint and Watchpoint Match Unit

This block sits beside the fetch and load/store stages of a 32-bit core and compares them against a small bank of debug slots. It has four instruction breakpoint slots and four data watchpoint slots. Configuration writes load one slot per cycle. A breakpoint slot holds a word address together with an enable bit. A watchpoint slot holds an exact byte address and a two-bit mode that says which kinds of access it reacts to.

A hit is reported in the same cycle as the fetch or data access that causes it. The core can then stall the access and take a debug exception before any state changes. Each hit strobe comes with a per-slot vector, so the core can tell whether any configured slot matched. The unit also drives a go signal for the data access, and this signal is held low whenever a watchpoint fires, so the access is suppressed.

Top module: `dbgm_match_unit`

## Requirements
- R1: After reset every breakpoint slot is disabled and every watchpoint slot has mode 00. With any fetch or data access, no hit is reported and `bp_slots`/`wp_slots` are zero.
- R2: The `bp_slots[i]` output is 1 in the same cycle as `fetch_valid` when slot i has its enable bit (bit 0 of the loaded address) set and `fetch_pc[31:2]` equals the slot's bits 31:2. `bp_hit` is the OR of `bp_slots`.
- R3: The breakpoint compare ignores `fetch_pc[1:0]` and bit 1 of the loaded slot value. A PC in a different word never hits.
- R4: A breakpoint slot whose enable bit is 0 never hits, whatever its address bits.
- R5: Watchpoint mode 01 hits on accesses with `mem_rd`=1 and mode 10 hits on accesses with `mem_wr`=1. Mode 11 hits on either. A hit needs `mem_valid`=1.
- R6: Watchpoint mode 00 never hits. Mode 01 ignores a write-only access and mode 10 ignores a read-only access.
- R7: A watchpoint matches only when all 32 bits of `mem_addr` equal its loaded address. An adjacent byte does not hit.
- R8: `mem_go` equals `mem_valid` with no watchpoint hit in the same cycle, and it is 0 whenever `wp_hit` is 1.
- R9: A configuration write (`cfg_we`=1; `cfg_bank` 0 selects breakpoints and 1 selects watchpoints; `cfg_idx` selects the slot) takes effect from the cycle after the clock edge that captures it. This applies to arming and to clearing alike.
- R10: `bp_hit` is 0 in any cycle where `fetch_valid` is 0, and `wp_hit` is 0 in any cycle where `mem_valid` is 0, so each strobe lasts only as long as its qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_bank | input | 1 | 0 = breakpoint bank, 1 = watchpoint bank |
| cfg_idx | input | 2 | Slot index |
| cfg_addr | input | 32 | Slot address (breakpoint: bit 0 is enable) |
| cfg_mode | input | 2 | Watchpoint mode: 00 off, 01 read, 10 write, 11 either |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | 32 | PC of the instruction about to execute |
| mem_valid | input | 1 | Data access present this cycle |
| mem_rd | input | 1 | Access reads |
| mem_wr | input | 1 | Access writes |
| mem_addr | input | 32 | Data byte address |
| bp_hit | output | 1 | Any breakpoint slot matched |
| bp_slots | output | 4 | Per-slot breakpoint match |
| wp_hit | output | 1 | Any watchpoint slot matched |
| wp_slots | output | 4 | Per-slot watchpoint match |
| mem_go | output | 1 | Data access may proceed |

## Verification
All match outputs are combinational from the current fetch and access inputs and the registered slot state. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and samples one nanosecond later. A configuration write lands at the next rising edge. The bench checks the old behaviour in the write cycle, and it updates its model only after that edge, before the next sample. This gives the one-cycle delay in R9 for both arming and clearing.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    WATCH_OFF = 2'b00,
    WATCH_RD  = 2'b01,
    WATCH_WR  = 2'b10,
    WATCH_ANY = 2'b11
  } watch_mode_e;

  // Word compare: the bits below WORD_LSB are shifted out of the difference
  function automatic logic word_match(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] diff;
    diff = (a ^ b) >> WORD_LSB;
    return diff == '0;
  endfunction

  // Mode bit 0 reacts to reads, bit 1 to writes
  function automatic logic mode_accepts(input watch_mode_e mode,
                                        input logic rd, input logic wr);
    return (mode[0] & rd) | (mode[1] & wr);
  endfunction
endpackage

// File: rtl/dbgm_bp_slot.sv
module dbgm_bp_slot
  import dbgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              hit
);
  logic [ADDR_W-1:0] slot_q;
  logic              slot_armed;
  logic              pc_same_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else if (wr_en) slot_q <= wr_addr;
  end

  assign slot_armed   = slot_q[0];
  assign pc_same_word = word_match(slot_q, fetch_pc);
  assign hit          = fetch_valid && slot_armed && pc_same_word;

  // Clearing the enable silences the slot from the next cycle
  assert_bp_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[0]) |=> !hit);

  // A write that arms a slot on the PC being fetched shows up next cycle
  assert_bp_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0] && fetch_valid && word_match(wr_addr, fetch_pc))
      |=> (!fetch_valid || !$stable(fetch_pc) || hit));
endmodule

// File: rtl/dbgm_wp_slot.sv
module dbgm_wp_slot
  import dbgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  watch_mode_e       wr_mode,
  input  logic              mem_valid,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] addr_q;
  watch_mode_e       mode_q;
  logic              kind_ok;
  logic              byte_same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= WATCH_OFF;
    end else if (wr_en) begin
      addr_q <= wr_addr;
      mode_q <= wr_mode;
    end
  end

  assign kind_ok   = mode_accepts(mode_q, mem_rd, mem_wr);
  assign byte_same = (addr_q == mem_addr);
  assign hit       = mem_valid && kind_ok && byte_same;

  assert_wp_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == WATCH_OFF) |=> !hit);

  // Read-only access can only hit a read-capable slot
  assert_wp_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mem_wr) |-> (mode_q == WATCH_RD || mode_q == WATCH_ANY));

  // Write-only access can only hit a write-capable slot
  assert_wp_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mem_rd) |-> (mode_q == WATCH_WR || mode_q == WATCH_ANY));
endmodule

// File: rtl/dbgm_match_unit.sv
module dbgm_match_unit
  import dbgm_pkg::*;
#(
  parameter int unsigned NUM_BP = 4,
  parameter int unsigned NUM_WP = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_mode,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              mem_valid,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              bp_hit,
  output logic [NUM_BP-1:0] bp_slots,
  output logic              wp_hit,
  output logic [NUM_WP-1:0] wp_slots,
  output logic              mem_go
);
  localparam logic BANK_BP = 1'b0;
  localparam logic BANK_WP = 1'b1;

  watch_mode_e cfg_mode_e;
  assign cfg_mode_e = watch_mode_e'(cfg_mode);

  logic [NUM_BP-1:0] bp_wr;
  logic [NUM_WP-1:0] wp_wr;

  for (genvar gb = 0; gb < NUM_BP; gb++) begin : g_bp
    assign bp_wr[gb] = cfg_we && (cfg_bank == BANK_BP) && (cfg_idx == IDX_W'(gb));
    dbgm_bp_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bp_wr[gb]),
      .wr_addr    (cfg_addr),
      .fetch_valid(fetch_valid),
      .fetch_pc   (fetch_pc),
      .hit        (bp_slots[gb])
    );
  end

  for (genvar gw = 0; gw < NUM_WP; gw++) begin : g_wp
    assign wp_wr[gw] = cfg_we && (cfg_bank == BANK_WP) && (cfg_idx == IDX_W'(gw));
    dbgm_wp_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wp_wr[gw]),
      .wr_addr  (cfg_addr),
      .wr_mode  (cfg_mode_e),
      .mem_valid(mem_valid),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .mem_addr (mem_addr),
      .hit      (wp_slots[gw])
    );
  end

  assign bp_hit = |bp_slots;
  assign wp_hit = |wp_slots;
  assign mem_go = mem_valid && !wp_hit;

  assert_bp_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> fetch_valid);

  assert_wp_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (mem_valid && (mem_rd || mem_wr)));

  assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> !mem_go);

  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bp_wr, wp_wr}));
endmodule

// File: tb/test_dbgm_match_unit.sv
module test_dbgm_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_bank = 1'b0;
  logic [1:0]  cfg_idx = '0, cfg_mode = '0;
  logic [31:0] cfg_addr = '0;
  logic        fetch_valid = 1'b0, mem_valid = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
  logic [31:0] fetch_pc = '0, mem_addr = '0;
  logic        bp_hit, wp_hit, mem_go;
  logic [3:0]  bp_slots, wp_slots;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_bp [4];
  logic [31:0] m_wa [4];
  logic [1:0]  m_wm [4];

  always #4 clk = ~clk;

  dbgm_match_unit i_dbgm_match_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .mem_valid(mem_valid),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .bp_hit(bp_hit), .bp_slots(bp_slots), .wp_hit(wp_hit),
    .wp_slots(wp_slots), .mem_go(mem_go));

  function automatic logic [3:0] exp_bp(logic v, logic [31:0] pc);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      r[k] = v && m_bp[k][0] && (m_bp[k][31:2] == pc[31:2]);
    return r;
  endfunction

  function automatic logic [3:0] exp_wp(logic v, logic rd, logic wr, logic [31:0] a);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      r[k] = v && (m_wa[k] == a) &&
             ((m_wm[k] == 2'b01 && rd) || (m_wm[k] == 2'b10 && wr) ||
              (m_wm[k] == 2'b11 && (rd || wr)));
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [3:0] eb, ew;
    eb = exp_bp(fetch_valid, fetch_pc);
    ew = exp_wp(mem_valid, mem_rd, mem_wr, mem_addr);
    chk(req, {28'd0, bp_slots}, {28'd0, eb});
    chk(req, {31'd0, bp_hit}, {31'd0, |eb});
    chk(req, {28'd0, wp_slots}, {28'd0, ew});
    chk(req, {31'd0, wp_hit}, {31'd0, |ew});
    chk({req, "/R8"}, {31'd0, mem_go}, {31'd0, mem_valid && !(|ew)});
  endtask

  // One cycle: drive at falling edge, check, then latch any config into the model
  task automatic step(string req, logic we, logic bank, logic [1:0] idx,
                      logic [31:0] ca, logic [1:0] cm,
                      logic fv, logic [31:0] pc,
                      logic mv, logic rd, logic wr, logic [31:0] ma);
    @(negedge clk);
    cfg_we = we; cfg_bank = bank; cfg_idx = idx; cfg_addr = ca; cfg_mode = cm;
    fetch_valid = fv; fetch_pc = pc;
    mem_valid = mv; mem_rd = rd; mem_wr = wr; mem_addr = ma;
    #1;
    check_all(req);
    @(posedge clk);
    if (we) begin
      if (!bank) m_bp[idx] = ca;
      else begin m_wa[idx] = ca; m_wm[idx] = cm; end
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] pc, ma;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 4; k++) begin m_bp[k] = '0; m_wa[k] = '0; m_wm[k] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state, address zero accesses of every kind
    step("R1", 0, 0, 0, 0, 0, 1, 32'h0, 1, 1, 1, 32'h0);
    step("R1", 0, 0, 0, 0, 0, 1, 32'h3, 1, 1, 0, 32'h0);

    // R9/R2/R3: arm bp0 while fetching its PC: no hit yet, hit next cycle
    step("R9", 1, 0, 0, 32'h0000_1001, 0, 1, 32'h1000, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 32'h1000, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 32'h1003, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 32'h1004, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 32'h1000, 0, 0, 0, 0);
    // R3: bit 1 of loaded value ignored
    step("R3", 1, 0, 2, 32'h0000_5003, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 32'h5000, 0, 0, 0, 0);
    // R4: address set but enable clear
    step("R4", 1, 0, 3, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 32'h7000, 0, 0, 0, 0);

    // Watchpoint modes on slot 1 at 0x2001
    step("R5", 1, 1, 1, 32'h0000_2001, 2'b01, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h2001);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 32'h2001);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h2000);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h2002);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h2001);
    step("R5", 1, 1, 1, 32'h0000_2001, 2'b10, 0, 0, 1, 0, 1, 32'h2001);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 32'h2001);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h2001);
    step("R5", 1, 1, 1, 32'h0000_2001, 2'b11, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h2001);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 32'h2001);
    // R9: clearing takes effect next cycle
    step("R9", 1, 1, 1, 32'h0000_2001, 2'b00, 0, 0, 1, 1, 1, 32'h2001);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 32'h2001);
    step("R9", 1, 0, 0, 32'h0000_1000, 0, 1, 32'h1000, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 32'h1000, 0, 0, 0, 0);

    // Random mix, addresses biased toward loaded slot values
    for (int it = 0; it < 3000; it++) begin
      logic we, bank;
      logic [1:0] idx, cm;
      logic [31:0] ca;
      we = ($urandom % 4) == 0;
      bank = $urandom % 2;
      idx = $urandom % 4;
      cm = $urandom % 4;
      ca = {20'h0, 4'($urandom % 4), 8'($urandom)};
      pc = m_bp[$urandom % 4] ^ (($urandom % 3 == 0) ? {24'h0, 8'($urandom)} : 32'($urandom % 4));
      ma = m_wa[$urandom % 4] ^ (($urandom % 3 == 0) ? 32'($urandom % 4) : 32'h0);
      step("R2/R5 random", we, bank, idx, ca, cm,
           1'($urandom), pc, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), ma);
    end
    report();
  end
endmodule